// File: doc/BRIEF.md
# Multi-Channel DMA Register Front End

This block is the 32-bit memory-mapped control face of a multi-channel DMA controller. The address space is cut into one 8 KiB window per channel. Inside a window, a word index selects a register. Each channel keeps its descriptor pointers, configuration, command, stream command and interrupt mask in its own slice. Each channel also tracks a run state: reset, stopped or running. The configuration register forces that state, and start and halt requests from the channel engine move it between stopped and running.

The data-moving engine stays outside. It receives a one-cycle continue strobe when software writes the command register, and a one-cycle stream strobe with a 10-bit operand when software writes the stream command register. It returns per-channel start and halt requests, an end-of-list flag, a stream command source code and interrupt set bits. Software reads a composed status word. It acknowledges interrupts by writing ones. Each channel drives a level interrupt while any unmasked raw cause is pending.

Requests are single-cycle. A read answers on the cycle after the request. Only full-word accesses with all four byte enables set are honoured. Any other access is flagged as an error and has no effect.

Top module: `dma_regif`

## Requirements
- R1: The channel index is `req_addr[AW-1:13]` and the word index is `req_addr[7:2]`. Address bits 12:8 and 1:0 are ignored, so a window aliases every 256 bytes. A channel index of NCH or more is answered with `rsp_err` and has no effect.
- R2: The words at byte offsets 0x00, 0x58, 0x5C, 0x60 and 0x7C are plain 32-bit storage that reads back what was written. Any offset not named in these requirements reads zero, and writes to it change nothing.
- R3: After reset, every channel is in the reset state, its status reads 0x1, all of its stored registers read zero, and all strobes and interrupt lines are low.
- R4: The configuration word (0x84) stores all 32 bits. A write with bit 0 clear forces the reset state. Otherwise, a write with bit 1 set forces the stopped state. Otherwise, the state is unchanged.
- R5: `eng_start` moves a stopped channel to running, and `eng_halt` moves a running channel to stopped. Both are ignored in any other state. A configuration write in the same cycle overrides them.
- R6: The status word (0x88) reads the state code in bits [2:0] (reset 1, stopped 2, running 4), `eng_eol` in bit 5, and the channel's `eng_src` field from bit 8 upward, with all other bits zero. Writes to it are ignored.
- R7: The command word (0x80) keeps only bit 0. Each write to it raises `cont_o` for the addressed channel alone, for exactly the cycle after the write.
- R8: The stream command word (0x9C) keeps only bits [9:0]. Each write to it raises `scmd_o` for the addressed channel for one cycle after the write, with `scmd_data_o` carrying the stored 10 bits.
- R9: Raw causes (0x94) are the low IRQW bits and are set by `irq_set`. The mask (0x8C) keeps the low IRQW bits. The masked word (0x98) reads raw AND mask. `irq_o[c]` is high exactly when channel c's masked word is nonzero.
- R10: Writing ones to the acknowledge word (0x90) clears the matching raw bits. If the engine sets a bit in the same cycle, the set wins. The acknowledge word reads zero.
- R11: An access with `req_be` other than 4'hF raises `rsp_err` on the next cycle, returns zero data, and changes no register and no state.
- R12: A valid read, or any erroring request, raises `rsp_valid` on the cycle after the request with the data. A successful write gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address (13 + channel index bits) |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data or error response present |
| rsp_err | output | 1 | Rejected access |
| rsp_rdata | output | 32 | Read data |
| eng_start | input | NCH | Per-channel request to enter running |
| eng_halt | input | NCH | Per-channel request to leave running |
| eng_eol | input | NCH | Per-channel end-of-list flag shown in status |
| eng_src | input | NCH*SRCW | Per-channel stream command source code |
| irq_set | input | NCH*IRQW | Per-channel raw interrupt set bits |
| irq_o | output | NCH | Per-channel level interrupt |
| cont_o | output | NCH | Per-channel continue strobe |
| scmd_o | output | NCH | Per-channel stream command strobe |
| scmd_data_o | output | 10 | Operand of the active stream command strobe |

## Verification
Two collisions in one cycle matter most. The first is an acknowledge write that lands on a bit the engine is setting at the same edge. The bench drives both in one cycle over a mix of overlapping and disjoint bits, and expects the set bits to survive while the other acknowledged bits clear. The second is a configuration write that coincides with an engine start request. There the bench expects the configuration to win when it forces a state, and the start request to take effect when the write forces nothing. Around these, sweeps cover every pair of raw and mask values, every configuration code from every state, and every unnamed word offset.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

    localparam int WORD_W  = 32;
    localparam int WIDX_W  = 6;
    localparam int SCMD_W  = 10;
    localparam int EOL_BIT = 5;
    localparam int SRC_LSB = 8;
    localparam int WIN_LSB = 13;

    // word indices inside a channel window (byte offset / 4)
    localparam logic [WIDX_W-1:0] W_DESC   = 6'h00;
    localparam logic [WIDX_W-1:0] W_SAVED  = 6'h16;
    localparam logic [WIDX_W-1:0] W_SBUF   = 6'h17;
    localparam logic [WIDX_W-1:0] W_GROUP  = 6'h18;
    localparam logic [WIDX_W-1:0] W_GDOWN  = 6'h1F;
    localparam logic [WIDX_W-1:0] W_CMD    = 6'h20;
    localparam logic [WIDX_W-1:0] W_CFG    = 6'h21;
    localparam logic [WIDX_W-1:0] W_STAT   = 6'h22;
    localparam logic [WIDX_W-1:0] W_MASK   = 6'h23;
    localparam logic [WIDX_W-1:0] W_ACK    = 6'h24;
    localparam logic [WIDX_W-1:0] W_RAW    = 6'h25;
    localparam logic [WIDX_W-1:0] W_MASKED = 6'h26;
    localparam logic [WIDX_W-1:0] W_SCMD   = 6'h27;

    typedef enum logic [2:0] {
        ST_RST  = 3'd1,
        ST_STOP = 3'd2,
        ST_RUN  = 3'd4
    } chan_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] desc;
        logic [WORD_W-1:0] saved;
        logic [WORD_W-1:0] sbuf;
        logic [WORD_W-1:0] group;
        logic [WORD_W-1:0] gdown;
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] raw;
        logic              cmd;
        logic [SCMD_W-1:0] scmd;
        chan_state_e       state;
        logic              cont;
        logic              scmd_p;
    } chan_regs_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [WORD_W-1:0] rdata;
    } rsp_t;

endpackage

// File: rtl/dma_regif_decode.sv
module dma_regif_decode
    import dma_regif_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = 2,
    parameter int AW  = 15
) (
    input  logic              valid,
    input  logic              write,
    input  logic [AW-1:0]     addr,
    input  logic [3:0]        be,
    output logic [CHW-1:0]    chan,
    output logic [WIDX_W-1:0] word,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              err
);
    logic in_range;
    logic full_word;
    logic unused_addr_bits;

    assign chan      = addr[AW-1:WIN_LSB];
    assign word      = addr[WIDX_W+1:2];
    assign full_word = (be == 4'hF);
    assign unused_addr_bits = ^{addr[WIN_LSB-1:WIDX_W+2], addr[1:0]};

    generate
        if (NCH == (1 << CHW)) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = (chan < CHW'(NCH));
        end
    endgenerate

    assign err   = valid && !(full_word && in_range);
    assign wr_ok = valid && full_word && in_range && write;
    assign rd_ok = valid && full_word && in_range && !write;

endmodule

// File: rtl/dma_regif_chan.sv
module dma_regif_chan
    import dma_regif_pkg::*;
#(
    parameter int IRQW = 4,
    parameter int SRCW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] word,
    input  logic [WORD_W-1:0] wdata,
    input  logic              eng_start,
    input  logic              eng_halt,
    input  logic              eng_eol,
    input  logic [SRCW-1:0]   eng_src,
    input  logic [IRQW-1:0]   irq_set,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq,
    output logic              cont,
    output logic              scmd_p,
    output logic [SCMD_W-1:0] scmd_val
);
    localparam logic [WORD_W-1:0] IRQ_KEEP =
        (IRQW >= WORD_W) ? {WORD_W{1'b1}} : WORD_W'((64'd1 << IRQW) - 64'd1);

    chan_regs_t        regs_d, regs_q;
    logic [WORD_W-1:0] set_w;
    logic [WORD_W-1:0] clr_w;
    logic [WORD_W-1:0] stat_w;
    logic              cfg_wr;

    assign set_w  = IRQ_KEEP & WORD_W'(irq_set);
    assign cfg_wr = wr_en && (word == W_CFG);

    always_comb begin
        regs_d        = regs_q;
        regs_d.cont   = 1'b0;
        regs_d.scmd_p = 1'b0;
        clr_w         = (wr_en && word == W_ACK) ? wdata : '0;
        regs_d.raw    = ((regs_q.raw & ~clr_w) | set_w) & IRQ_KEEP;

        if (eng_halt && regs_q.state == ST_RUN) begin
            regs_d.state = ST_STOP;
        end
        if (eng_start && regs_q.state == ST_STOP) begin
            regs_d.state = ST_RUN;
        end

        if (wr_en) begin
            case (word)
                W_DESC:  regs_d.desc  = wdata;
                W_SAVED: regs_d.saved = wdata;
                W_SBUF:  regs_d.sbuf  = wdata;
                W_GROUP: regs_d.group = wdata;
                W_GDOWN: regs_d.gdown = wdata;
                W_MASK:  regs_d.mask  = wdata & IRQ_KEEP;
                W_CMD: begin
                    regs_d.cmd  = wdata[0];
                    regs_d.cont = 1'b1;
                end
                W_SCMD: begin
                    regs_d.scmd   = wdata[SCMD_W-1:0];
                    regs_d.scmd_p = 1'b1;
                end
                W_CFG: begin
                    regs_d.cfg = wdata;
                    if (!wdata[0]) begin
                        regs_d.state = ST_RST;
                    end else if (wdata[1]) begin
                        regs_d.state = ST_STOP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.state <= ST_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        stat_w                    = '0;
        stat_w[2:0]               = regs_q.state;
        stat_w[EOL_BIT]           = eng_eol;
        stat_w[SRC_LSB +: SRCW]   = eng_src;
    end

    always_comb begin
        case (word)
            W_DESC:   rd_data = regs_q.desc;
            W_SAVED:  rd_data = regs_q.saved;
            W_SBUF:   rd_data = regs_q.sbuf;
            W_GROUP:  rd_data = regs_q.group;
            W_GDOWN:  rd_data = regs_q.gdown;
            W_CMD:    rd_data = WORD_W'(regs_q.cmd);
            W_CFG:    rd_data = regs_q.cfg;
            W_STAT:   rd_data = stat_w;
            W_MASK:   rd_data = regs_q.mask;
            W_RAW:    rd_data = regs_q.raw;
            W_MASKED: rd_data = regs_q.raw & regs_q.mask;
            W_SCMD:   rd_data = WORD_W'(regs_q.scmd);
            default:  rd_data = '0;
        endcase
    end

    assign irq      = |(regs_q.raw & regs_q.mask);
    assign cont     = regs_q.cont;
    assign scmd_p   = regs_q.scmd_p;
    assign scmd_val = regs_q.scmd;

    AST_CFG_FORCE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !wdata[0] |=> regs_q.state == ST_RST); // R4
    AST_CFG_FORCE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && wdata[0] && wdata[1] |=> regs_q.state == ST_STOP); // R4
    AST_RST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.state == ST_RST && !cfg_wr |=> regs_q.state == ST_RST); // R5
    AST_CONT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && word == W_CMD |=> cont); // R7
    AST_SCMD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && word == W_SCMD |=> scmd_p && scmd_val == $past(wdata[SCMD_W-1:0])); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        |irq_set |=> (regs_q.raw[IRQW-1:0] & $past(irq_set)) == $past(irq_set)); // R10

endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dma_regif_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int IRQW = 4,
    parameter int SRCW = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW  = WIN_LSB + CHW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [AW-1:0]          req_addr,
    input  logic [3:0]             req_be,
    input  logic [WORD_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [WORD_W-1:0]      rsp_rdata,
    input  logic [NCH-1:0]         eng_start,
    input  logic [NCH-1:0]         eng_halt,
    input  logic [NCH-1:0]         eng_eol,
    input  logic [NCH*SRCW-1:0]    eng_src,
    input  logic [NCH*IRQW-1:0]    irq_set,
    output logic [NCH-1:0]         irq_o,
    output logic [NCH-1:0]         cont_o,
    output logic [NCH-1:0]         scmd_o,
    output logic [SCMD_W-1:0]      scmd_data_o
);
    localparam int NSLOT = 1 << CHW;

    logic [CHW-1:0]    dec_chan;
    logic [WIDX_W-1:0] dec_word;
    logic              dec_wr, dec_rd, dec_err;
    logic [WORD_W-1:0] rd_words [NSLOT];
    logic [SCMD_W-1:0] scmd_vals [NCH];
    rsp_t              rsp_d, rsp_q;

    dma_regif_decode #(.NCH(NCH), .CHW(CHW), .AW(AW)) u_decode (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .be    (req_be),
        .chan  (dec_chan),
        .word  (dec_word),
        .wr_ok (dec_wr),
        .rd_ok (dec_rd),
        .err   (dec_err)
    );

    for (genvar c = 0; c < NSLOT; c++) begin : g_ch
        if (c < NCH) begin : g_live
            dma_regif_chan #(.IRQW(IRQW), .SRCW(SRCW)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (dec_wr && dec_chan == CHW'(c)),
                .word      (dec_word),
                .wdata     (req_wdata),
                .eng_start (eng_start[c]),
                .eng_halt  (eng_halt[c]),
                .eng_eol   (eng_eol[c]),
                .eng_src   (eng_src[c*SRCW +: SRCW]),
                .irq_set   (irq_set[c*IRQW +: IRQW]),
                .rd_data   (rd_words[c]),
                .irq       (irq_o[c]),
                .cont      (cont_o[c]),
                .scmd_p    (scmd_o[c]),
                .scmd_val  (scmd_vals[c])
            );
        end else begin : g_hole
            assign rd_words[c] = '0;
        end
    end

    always_comb begin
        scmd_data_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (scmd_o[c]) begin
                scmd_data_o = scmd_data_o | scmd_vals[c];
            end
        end
    end

    always_comb begin
        rsp_d.valid = dec_rd || dec_err;
        rsp_d.err   = dec_err;
        rsp_d.rdata = dec_rd ? rd_words[dec_chan] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    AST_PARTIAL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_be != 4'hF |=> rsp_err && rsp_rdata == '0); // R11
    AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid); // R12
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cont_o) && $onehot0(scmd_o)); // R7

endmodule

// File: tb/dma_regif_tb.sv
module dma_regif_tb;
    localparam int CLK_P = 10;
    localparam int NCH   = 3;
    localparam int IRQW  = 4;
    localparam int SRCW  = 2;
    localparam int AW    = 15;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0] req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [NCH-1:0] eng_start = '0, eng_halt = '0, eng_eol = '0;
    logic [NCH*SRCW-1:0] eng_src = '0;
    logic [NCH*IRQW-1:0] irq_set = '0;
    logic [NCH-1:0] irq_o, cont_o, scmd_o;
    logic [9:0] scmd_data_o;

    int checks = 0, fails = 0;
    logic [31:0] r_data;
    logic r_err, r_vld;
    logic [NCH-1:0] s_cont, s_scmd, s_irq;
    logic [9:0] s_sdata;

    always #(CLK_P/2) clk = ~clk;

    dma_regif #(.NCH(NCH), .IRQW(IRQW), .SRCW(SRCW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .eng_start(eng_start), .eng_halt(eng_halt), .eng_eol(eng_eol),
        .eng_src(eng_src), .irq_set(irq_set), .irq_o(irq_o), .cont_o(cont_o),
        .scmd_o(scmd_o), .scmd_data_o(scmd_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input int ch, input int w, input logic [31:0] d,
                       input logic [3:0] be, input int xaddr);
        req_valid = 1; req_write = wr; req_be = be; req_wdata = d;
        req_addr  = AW'((ch << 13) | (w << 2) | xaddr);
        @(negedge clk);
        r_data = rsp_rdata; r_err = rsp_err; r_vld = rsp_valid;
        s_cont = cont_o; s_scmd = scmd_o; s_sdata = scmd_data_o; s_irq = irq_o;
        req_valid = 0; req_write = 0; req_be = 4'hF;
    endtask

    task automatic wr(input int ch, input int w, input logic [31:0] d);
        acc(1, ch, w, d, 4'hF, 0);
    endtask

    task automatic rd(input int ch, input int w);
        acc(0, ch, w, 32'h0, 4'hF, 0);
    endtask

    task automatic set_irq(input int ch, input logic [3:0] v);
        irq_set[ch*IRQW +: IRQW] = v;
        @(negedge clk);
        irq_set = '0;
    endtask

    task automatic go_state(input int ch, input int st);
        wr(ch, 'h21, 32'h0);
        if (st >= 2) wr(ch, 'h21, 32'h3);
        if (st == 4) begin
            eng_start[ch] = 1'b1;
            @(negedge clk);
            eng_start = '0;
        end
    endtask

    function automatic logic [31:0] pat(input int ch, input int w);
        return 32'h9E3779B9 * (ch * 64 + w + 1);
    endfunction

    function automatic bit named(input int w);
        return (w == 'h00) || (w >= 'h16 && w <= 'h18) || (w == 'h1F) ||
               (w >= 'h20 && w <= 'h27);
    endfunction

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int stor[5];
        stor = '{'h00, 'h16, 'h17, 'h18, 'h1F};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R3 reset state
        chk("R3 irq", 32'(irq_o), 0);
        chk("R3 cont", 32'(cont_o), 0);
        chk("R3 scmd", 32'(scmd_o), 0);
        for (int c = 0; c < NCH; c++) begin
            rd(c, 'h22); chk("R3 status", r_data, 32'h1);
            rd(c, 'h21); chk("R3 cfg", r_data, 0);
            rd(c, 'h25); chk("R3 raw", r_data, 0);
            for (int i = 0; i < 5; i++) begin
                rd(c, stor[i]); chk("R3 storage", r_data, 0);
            end
        end

        // R2 storage words per channel
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 5; i++) wr(c, stor[i], pat(c, stor[i]));
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 5; i++) begin
                rd(c, stor[i]); chk("R2 readback", r_data, pat(c, stor[i]));
                chk("R12 read valid", 32'(r_vld), 1);
            end

        // R1 aliasing of bits 12:8 and 1:0
        acc(1, 1, 'h00, 32'h1234ABCD, 4'hF, 'h1F03);
        chk("R12 write no rsp", 32'(r_vld), 0);
        rd(1, 'h00); chk("R1 alias write", r_data, 32'h1234ABCD);
        acc(0, 1, 'h00, 0, 4'hF, 'h0A00); chk("R1 alias read", r_data, 32'h1234ABCD);
        // R1 out-of-range channel
        acc(1, 3, 'h00, 32'hFFFFFFFF, 4'hF, 0);
        chk("R1 oor err", 32'(r_err), 1);
        chk("R1 oor valid", 32'(r_vld), 1);
        rd(0, 'h00); chk("R1 oor no effect", r_data, pat(0, 'h00));

        // R2 unnamed offsets
        for (int w = 0; w < 64; w++) begin
            if (!named(w)) begin
                wr(2, w, 32'hFFFFFFFF);
                rd(2, w); chk("R2 unnamed reads zero", r_data, 0);
            end
        end
        for (int i = 0; i < 5; i++) begin
            rd(2, stor[i]); chk("R2 unnamed no side effect", r_data, pat(2, stor[i]));
        end

        // R4 config sweep from each state
        for (int s = 0; s < 3; s++)
            for (int v = 0; v < 4; v++) begin
                int st;
                int ex;
                st = 1 << s;
                go_state(0, st);
                rd(0, 'h22); chk("R5 reach state", r_data, 32'(st));
                wr(0, 'h21, 32'hC0DE0000 | v);
                ex = (v[0] == 0) ? 1 : (v[1] ? 2 : st);
                rd(0, 'h22); chk("R4 cfg state", r_data, 32'(ex));
                rd(0, 'h21); chk("R4 cfg stored", r_data, 32'hC0DE0000 | v);
            end

        // R5 engine requests
        go_state(1, 1);
        eng_start[1] = 1; @(negedge clk); eng_start = '0;
        rd(1, 'h22); chk("R5 start ignored in reset", r_data, 1);
        go_state(1, 4);
        eng_halt[1] = 1; @(negedge clk); eng_halt = '0;
        rd(1, 'h22); chk("R5 halt", r_data, 2);
        eng_halt[1] = 1; @(negedge clk); eng_halt = '0;
        rd(1, 'h22); chk("R5 halt ignored when stopped", r_data, 2);
        eng_start[1] = 1; wr(1, 'h21, 32'h0); eng_start = '0;
        rd(1, 'h22); chk("R5 cfg beats start", r_data, 1);
        go_state(1, 2);
        eng_start[1] = 1; wr(1, 'h21, 32'h1); eng_start = '0;
        rd(1, 'h22); chk("R5 start with passive cfg", r_data, 4);

        // R6 status composition
        for (int c = 0; c < NCH; c++) begin
            go_state(c, 2);
            eng_eol[c] = 1;
            eng_src[c*SRCW +: SRCW] = SRCW'(c + 1);
            rd(c, 'h22); chk("R6 status", r_data, 32'(2 | 32 | ((c + 1) << 8)));
            wr(c, 'h22, 32'hFFFFFFFF);
            rd(c, 'h22); chk("R6 status write ignored", r_data, 32'(2 | 32 | ((c + 1) << 8)));
            eng_eol = '0; eng_src = '0;
        end

        // R7 continue / R8 stream command
        for (int c = 0; c < NCH; c++) begin
            wr(c, 'h20, 32'hFFFFFFFF);
            chk("R7 cont strobe", 32'(s_cont), 32'(1 << c));
            @(negedge clk);
            chk("R7 cont one cycle", 32'(cont_o), 0);
            rd(c, 'h20); chk("R7 cmd keeps bit0", r_data, 1);
            wr(c, 'h27, 32'hFFFFF3A5 ^ c);
            chk("R8 scmd strobe", 32'(s_scmd), 32'(1 << c));
            chk("R8 scmd data", 32'(s_sdata), (32'h3A5 ^ c));
            @(negedge clk);
            chk("R8 scmd one cycle", 32'(scmd_o), 0);
            rd(c, 'h27); chk("R8 scmd stored", r_data, (32'h3A5 ^ c));
        end

        // R9 raw x mask sweep on channel 2
        for (int r = 0; r < 16; r++)
            for (int m = 0; m < 16; m++) begin
                wr(2, 'h24, 32'hF);
                set_irq(2, 4'(r));
                wr(2, 'h23, 32'hFFFFFFF0 | m);
                chk("R9 irq level", 32'(s_irq[2]), 32'((r & m) != 0));
                rd(2, 'h98 >> 2); chk("R9 masked", r_data, 32'(r & m));
                rd(2, 'h25); chk("R9 raw", r_data, 32'(r));
                rd(2, 'h23); chk("R9 mask kept", r_data, 32'(m));
            end

        // R10 acknowledge and same-cycle set
        wr(0, 'h24, 32'hF);
        set_irq(0, 4'b0011);
        rd(0, 'h24); chk("R10 ack reads zero", r_data, 0);
        irq_set[0 +: IRQW] = 4'b0100;
        wr(0, 'h24, 32'h6);
        irq_set = '0;
        rd(0, 'h25); chk("R10 set wins over ack", r_data, 32'b0101);
        irq_set[0 +: IRQW] = 4'b0001;
        wr(0, 'h24, 32'h1);
        irq_set = '0;
        rd(0, 'h25); chk("R10 same bit set and ack", r_data, 32'b0101);
        wr(0, 'h24, 32'h5);
        rd(0, 'h25); chk("R10 ack clears", r_data, 0);

        // R11 partial accesses
        acc(1, 0, 'h00, 32'h0BADF00D, 4'b0011, 0);
        chk("R11 partial write err", 32'(r_err), 1);
        rd(0, 'h00); chk("R11 no write effect", r_data, pat(0, 'h00));
        acc(0, 0, 'h00, 0, 4'b1110, 0);
        chk("R11 partial read err", 32'(r_err), 1);
        chk("R11 partial read data", r_data, 0);
        acc(1, 1, 'h20, 32'h1, 4'b0001, 0);
        chk("R11 no strobe", 32'(s_cont), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule